// File: doc/BRIEF.md
# Step-Coded Multichannel PWM Generator

This block drives a set of independent PWM outputs (four by default) from a shared reference tick. Each channel is set by a rate byte, a duty byte, an invert bit and an enable bit, all held by logic outside the block. The rate byte has two parts. A 2-bit step code in bits 7:6 selects a unit of 0.5, 2, 8 or 32 Hz. A 6-bit multiplier in bits 5:0, plus one, scales that unit. The output frequency therefore runs from 0.5 Hz to 2048 Hz.

Each channel keeps a phase accumulator. On every reference tick it adds the channel's increment, which is (multiplier+1) shifted left by twice the step code. The accumulator wraps at a power-of-two modulus, with one increment unit equal to 0.5 Hz at the nominal tick rate. The top eight bits of the accumulator are the phase. While the phase is at or below the duty byte, the channel's raw waveform is high. The high share of each period is therefore (duty+1)/256, and a 0% duty cycle cannot be produced. Configuration inputs act on the output at once. The running accumulator is never resynchronised when they change, so one period can mix old and new settings.

Top module: `stepcode_pwm`

## Requirements
- R1: The rate byte is decoded as step code = bits 7:6 and multiplier = bits 5:0. The accumulator (ACC_W bits) advances by (multiplier+1)<<(2*step) on each tick and wraps modulo 2^ACC_W. The period is therefore 2^ACC_W/increment ticks when the increment divides the modulus. Two bytes that give the same increment (for example 0xC0 and 0x4F) give the same waveform.
- R2: An enabled, non-inverted output is high exactly while the top 8 accumulator bits are at or below the duty byte. Over one period it is high on ceil((duty+1)*2^(ACC_W-8)/increment) ticks, and a duty byte of 255 gives a constant high.
- R3: A disabled channel's output is low whatever its invert bit is. While the channel is disabled its accumulator is cleared, so enabling it again starts from phase 0.
- R4: When a channel is enabled and its invert bit is 1, its output is the complement of the non-inverted waveform.
- R5: Changes to duty, invert or rate bytes reach the output in the same cycle. They do not reset the accumulator, which keeps counting from its current value.
- R6: The accumulator changes only on cycles where ref_tick is 1. With ref_tick held at 0, an enabled output holds its level.
- R7: Channels are independent. Each one's waveform depends only on its own configuration, the shared tick and the reset.
- R8: While rst_n is low and after it is released, every accumulator is zero and every output is low until a channel is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference tick; a clock enable for all accumulators |
| freq_cfg | input | NUM_CH*8 | Per-channel rate bytes, channel i in bits [8i+7:8i] |
| duty_cfg | input | NUM_CH*8 | Per-channel duty bytes, channel i in bits [8i+7:8i] |
| inv_cfg | input | NUM_CH | Per-channel output invert |
| en_cfg | input | NUM_CH | Per-channel enable |
| pwm_out | output | NUM_CH | PWM outputs |

## Verification
The assertions check several rules on every cycle: a disabled channel is low, a disabled accumulator is cleared, the phase is frozen when no tick arrives, and duty 255 forces a constant level whose sense follows the invert bit. Only the bench's scenarios can show the rest. These are the exact high-tick count over whole periods for each step code, the equivalence of different byte encodings, mid-period changes that take effect without a counter restart, and several channels running different settings at the same time.

// File: rtl/stepcode_pwm_pkg.sv
package stepcode_pwm_pkg;
   localparam int PHASE_W = 8;
   localparam int CFG_W   = 8;
   localparam int INC_W   = 13;

   typedef struct packed {
      logic [1:0] step;
      logic [5:0] mult;
   } rate_cfg_t;

   function automatic logic [INC_W-1:0] unit_increment(rate_cfg_t r);
      logic [INC_W-1:0] base;
      base = {7'b0, r.mult} + 13'd1;
      return base << {r.step, 1'b0};
   endfunction
endpackage

// File: rtl/stepcode_pwm_rate.sv
module stepcode_pwm_rate
   import stepcode_pwm_pkg::*;
(
   input  logic [CFG_W-1:0] rate_byte,
   output logic [INC_W-1:0] increment
);
   rate_cfg_t rate;
   assign rate      = rate_cfg_t'(rate_byte);
   assign increment = unit_increment(rate);
endmodule

// File: rtl/stepcode_pwm_accum.sv
module stepcode_pwm_accum
   import stepcode_pwm_pkg::*;
#(
   parameter int ACC_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               enable,
   input  logic [INC_W-1:0]   increment,
   output logic [PHASE_W-1:0] phase
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] inc_ext;

   generate
      if (ACC_W == INC_W) begin : g_nopad
         assign inc_ext = increment;
      end else begin : g_pad
         assign inc_ext = {{(ACC_W-INC_W){1'b0}}, increment};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (!enable) acc_q <= '0;
      else if (tick)    acc_q <= acc_q + inc_ext;
   end

   assign phase = acc_q[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/stepcode_pwm_shape.sv
module stepcode_pwm_shape
   import stepcode_pwm_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] phase,
   input  logic [CFG_W-1:0]   duty,
   input  logic               invert,
   input  logic               enable,
   output logic               pin
);
   logic raw;
   logic shaped;

   assign raw    = (phase <= duty);
   assign shaped = enable & (raw ^ invert);

   generate
      if (OUT_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= shaped;
         end
         assign pin = pin_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pin = shaped;
      end
   endgenerate
endmodule

// File: rtl/stepcode_pwm.sv
module stepcode_pwm
   import stepcode_pwm_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int ACC_W   = 20,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ref_tick,
   input  logic [NUM_CH*CFG_W-1:0] freq_cfg,
   input  logic [NUM_CH*CFG_W-1:0] duty_cfg,
   input  logic [NUM_CH-1:0]       inv_cfg,
   input  logic [NUM_CH-1:0]       en_cfg,
   output logic [NUM_CH-1:0]       pwm_out
);
   localparam int MIN_ACC_W = INC_W;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (ACC_W < MIN_ACC_W) begin : g_bad_acc
         $error("ACC_W must be at least INC_W");
      end
   endgenerate

   logic [NUM_CH*PHASE_W-1:0] phase_all;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic [INC_W-1:0]   inc;
         logic [PHASE_W-1:0] phase;

         stepcode_pwm_rate u_rate (
            .rate_byte (freq_cfg[i*CFG_W +: CFG_W]),
            .increment (inc)
         );

         stepcode_pwm_accum #(.ACC_W(ACC_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (ref_tick),
            .enable    (en_cfg[i]),
            .increment (inc),
            .phase     (phase)
         );

         stepcode_pwm_shape #(.OUT_REG(OUT_REG)) u_shape (
            .clk    (clk),
            .rst_n  (rst_n),
            .phase  (phase),
            .duty   (duty_cfg[i*CFG_W +: CFG_W]),
            .invert (inv_cfg[i]),
            .enable (en_cfg[i]),
            .pin    (pwm_out[i])
         );

         assign phase_all[i*PHASE_W +: PHASE_W] = phase;
      end
   endgenerate
endmodule

// File: rtl/stepcode_pwm_chk.sv
module stepcode_pwm_chk #(
   parameter int NUM_CH  = 4,
   parameter bit OUT_REG = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ref_tick,
   input logic [NUM_CH*8-1:0] duty_cfg,
   input logic [NUM_CH-1:0]   inv_cfg,
   input logic [NUM_CH-1:0]   en_cfg,
   input logic [NUM_CH-1:0]   pwm_out,
   input logic [NUM_CH*8-1:0] phase_all
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_c
         // R3
         disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_cfg[i] |=> (phase_all[i*8 +: 8] == 8'd0));
         // R6
         no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_cfg[i] && !ref_tick) |=> $stable(phase_all[i*8 +: 8]));
         if (OUT_REG == 1'b0) begin : g_comb
            // R3
            disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !en_cfg[i] |-> !pwm_out[i]);
            // R2
            full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_cfg[i] && !inv_cfg[i] && duty_cfg[i*8 +: 8] == 8'hFF) |-> pwm_out[i]);
            // R4
            full_duty_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_cfg[i] && inv_cfg[i] && duty_cfg[i*8 +: 8] == 8'hFF) |-> !pwm_out[i]);
         end else begin : g_reg
            // R3
            disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !en_cfg[i] |=> !pwm_out[i]);
            // R2
            full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_cfg[i] && !inv_cfg[i] && duty_cfg[i*8 +: 8] == 8'hFF) |=> pwm_out[i]);
            // R4
            full_duty_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (en_cfg[i] && inv_cfg[i] && duty_cfg[i*8 +: 8] == 8'hFF) |=> !pwm_out[i]);
         end
      end
   endgenerate
endmodule

bind stepcode_pwm stepcode_pwm_chk #(.NUM_CH(NUM_CH), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .duty_cfg  (duty_cfg),
   .inv_cfg   (inv_cfg),
   .en_cfg    (en_cfg),
   .pwm_out   (pwm_out),
   .phase_all (phase_all)
);

// File: tb/stepcode_pwm_tb.sv
module stepcode_pwm_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 4;
   localparam int ACCW  = 13;
   localparam int NVEC  = 8;

   // rate byte, duty byte, invert, window length, expected high ticks
   localparam int V_FREQ[NVEC] = '{8'hFF, 8'h00, 8'h43, 8'h87, 8'h81, 8'hC0, 8'h4F, 8'h1F};
   localparam int V_DUTY[NVEC] = '{127,   0,     63,    255,   31,    200,   0,     99};
   localparam int V_INV [NVEC] = '{0,     0,     0,     0,     1,     0,     0,     1};
   localparam int V_PER [NVEC] = '{2,     8192,  512,   64,    256,   128,   128,   256};
   localparam int V_HIGH[NVEC] = '{1,     32,    128,   64,    224,   101,   1,     156};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ref_tick = 1'b1;
   logic [NCH*8-1:0] freq_cfg = '0;
   logic [NCH*8-1:0] duty_cfg = '0;
   logic [NCH-1:0]   inv_cfg = '0;
   logic [NCH-1:0]   en_cfg = '0;
   logic [NCH-1:0]   pwm_out;

   int n_chk = 0;
   int n_bad = 0;
   int hcnt[NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   stepcode_pwm #(.NUM_CH(NCH), .ACC_W(ACCW), .OUT_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .freq_cfg(freq_cfg), .duty_cfg(duty_cfg),
      .inv_cfg(inv_cfg), .en_cfg(en_cfg), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_ch(input int ch, input int f, input int d, input bit inv, input bit en);
      freq_cfg[ch*8 +: 8] = f[7:0];
      duty_cfg[ch*8 +: 8] = d[7:0];
      inv_cfg[ch] = inv;
      en_cfg[ch]  = en;
   endtask

   // called at a negedge; counts high samples over n cycles, ends at a negedge
   task automatic count_window(input int n);
      for (int c = 0; c < NCH; c++) hcnt[c] = 0;
      for (int k = 0; k < n; k++) begin
         #1;
         for (int c = 0; c < NCH; c++) hcnt[c] += int'(pwm_out[c]);
         @(negedge clk);
      end
   endtask

   task automatic all_off();
      @(negedge clk);
      en_cfg = '0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R8 / R3: reset state, inverted but disabled channels stay low
      inv_cfg = '1;
      duty_cfg = '1;
      repeat (3) @(negedge clk);
      #1 check("R8 outputs low in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1 check("R3 disabled inverted channels low", int'(pwm_out), 0);
      inv_cfg = '0;

      // table walk: R1 period, R2 duty, R4 invert, R7 others idle
      for (int v = 0; v < NVEC; v++) begin
         int ch;
         ch = v % NCH;
         all_off();
         set_ch(ch, V_FREQ[v], V_DUTY[v], V_INV[v] != 0, 1'b1);
         count_window(V_PER[v]);
         check($sformatf("R1/R2/R4 vector %0d high ticks", v), hcnt[ch], V_HIGH[v]);
         check($sformatf("R7 vector %0d idle channels", v),
               hcnt[0] + hcnt[1] + hcnt[2] + hcnt[3] - hcnt[ch], 0);
         en_cfg[ch] = 1'b0;
         inv_cfg = '0;
      end

      // R5: mid-period changes with no counter restart (increment 1, phase = acc>>5)
      all_off();
      set_ch(2, 8'h00, 0, 1'b0, 1'b1);
      count_window(100);                       // acc = 100, phase 3
      #1 check("R5 before duty change low", int'(pwm_out[2]), 0);
      duty_cfg[2*8 +: 8] = 8'd5;
      #1 check("R5 duty change immediate", int'(pwm_out[2]), 1);
      inv_cfg[2] = 1'b1;
      #1 check("R4/R5 invert change immediate", int'(pwm_out[2]), 0);
      inv_cfg[2] = 1'b0;
      @(negedge clk);                          // acc = 101
      count_window(90);                        // acc = 191, phase 5
      #1 check("R5 counter kept running (phase 5)", int'(pwm_out[2]), 1);
      @(negedge clk);                          // acc = 192, phase 6
      #1 check("R5 counter kept running (phase 6)", int'(pwm_out[2]), 0);

      // R3: disable forces low, re-enable restarts at phase 0
      en_cfg[2] = 1'b0;
      #1 check("R3 disable forces low", int'(pwm_out[2]), 0);
      @(negedge clk);
      en_cfg[2] = 1'b1;
      #1 check("R3 restart from phase 0", int'(pwm_out[2]), 1);

      // R6: no tick, accumulator holds (fast rate would otherwise move it)
      freq_cfg[2*8 +: 8] = 8'hFF;
      duty_cfg[2*8 +: 8] = 8'd0;
      ref_tick = 1'b0;
      count_window(10);
      check("R6 output held without tick", hcnt[2], 10);
      ref_tick = 1'b1;
      count_window(2);
      check("R6 resumes with tick", hcnt[2], 1);

      // R7: three channels together over 256 cycles
      all_off();
      set_ch(0, 8'hFF, 127, 1'b0, 1'b1);
      set_ch(1, 8'hC0, 200, 1'b0, 1'b1);
      set_ch(3, 8'h81, 31,  1'b1, 1'b1);
      count_window(256);
      check("R7 channel 0 concurrent", hcnt[0], 128);
      check("R7 channel 1 concurrent", hcnt[1], 202);
      check("R7 channel 2 idle", hcnt[2], 0);
      check("R7 channel 3 concurrent", hcnt[3], 224);

      summary();
   end
endmodule